// File: doc/BRIEF.md
# Bus-Based Accumulator Processor

This block is a small 8-bit processor whose registers all exchange data over one shared 8-bit bus. It holds a 4-bit program counter, a memory address register, a 16-word by 8-bit memory shared by code and data, an instruction register, an accumulator, a second operand register, a combinational two's-complement adder/subtracter and an output register that drives an 8-bit LED port. Each cycle, exactly one source may place a value on the bus. The bus is built as a gated OR of the enabled sources, so it never needs real tri-state drivers.

Software is loaded through a program port. While `prog_mode` is high, the memory address comes from `prog_addr`, and `prog_data` is written on each rising edge where `prog_we` is high. The processor itself stays idle. When `prog_mode` is lowered, the controller starts fetching from the current program counter.

The controller is a state machine. Its fetch steps are ST_ADDR (program counter onto the bus, memory address register loads), ST_INCR (program counter advances) and ST_FETCH (memory onto the bus, instruction register loads). Its execute steps are ST_EX1, ST_EX2 and ST_EX3, after which it returns to ST_ADDR. From ST_EX1 it goes to ST_HALT when the opcode is halt, and ST_HALT is left only by clear. In any state other than ST_HALT, a high `prog_mode` sends the next state to ST_ADDR.

Top module: `busacc_cpu`

## Requirements
- R1: While `prog_mode` is high, a rising edge with `prog_we` high writes `prog_data` to the word at `prog_addr`. No instruction executes, and `leds` and the accumulator hold their values.
- R2: Asserting `clr` (asynchronous, active high) zeroes the program counter, the address, instruction, accumulator, operand and output registers, and `leds`. It sends the controller to ST_ADDR with `halted` low. Memory contents are kept.
- R3: Opcode 0000 in bits 7:4 loads the accumulator from the memory word addressed by bits 3:0.
- R4: Opcode 0001 adds the addressed memory word to the accumulator, modulo 256.
- R5: Opcode 0010 subtracts the addressed memory word from the accumulator as A + ~B + 1, modulo 256.
- R6: Opcode 1110 copies the accumulator to the output register shown on `leds`. Its bits 3:0 are ignored.
- R7: Opcode 1111 raises `halted`, and its bits 3:0 are ignored. From then until `clr`, no register changes, `leds` stays fixed and later words are not executed.
- R8: Every instruction takes six clock cycles (three fetch and three execute). With k instructions ahead of a halt, `halted` rises on the (6k+4)th rising edge after `prog_mode` falls. The program counter wraps from 15 to 0.
- R9: At most one bus source is enabled in any cycle.
- R10: Opcodes other than the five above execute as no-operations that change no register.
- R11: While `prog_mode` is low, `prog_we`, `prog_addr` and `prog_data` have no effect on memory or on results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clr | input | 1 | Asynchronous clear, active high |
| prog_mode | input | 1 | High: program loading, processor idle; low: run |
| prog_we | input | 1 | Memory write strobe used in program mode |
| prog_addr | input | 4 | Memory address used in program mode |
| prog_data | input | 8 | Word written in program mode |
| leds | output | 8 | Output register contents |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
An add/subtract chain of the form a+b-c+d-e is swept over forty arithmetic operand sets, plus hand-picked wrap cases (255+1, 0-1, 128+128). This separates correct modulo-256 add and subtract from swapped operands, missing carry-in and wrong operand routing. Between the output instruction and the halt, the low nibbles vary to show they are ignored. A load and output after the halt carry data that differs from the expected result, which exposes a halt that fails to freeze the machine. Separate programs cover a plain load/output over boundary values, undefined opcodes that must leave the accumulator alone, and a sixteen-word loop that only yields the expected LED value when the program counter wraps. The halt cycle count is checked against 6k+4, and run-mode write attempts target an operand word to show they are discarded.

// File: rtl/busacc_pkg.sv
package busacc_pkg;

    typedef enum logic [3:0] {
        OP_LDA = 4'b0000,
        OP_ADD = 4'b0001,
        OP_SUB = 4'b0010,
        OP_OUT = 4'b1110,
        OP_HLT = 4'b1111
    } opcode_e;

    typedef enum logic [2:0] {
        ST_ADDR,
        ST_INCR,
        ST_FETCH,
        ST_EX1,
        ST_EX2,
        ST_EX3,
        ST_HALT
    } state_e;

    // one control word per step, twelve strobes
    typedef struct packed {
        logic pc_inc;
        logic pc_oe;
        logic mar_ld;
        logic mem_oe;
        logic ir_ld;
        logic ir_oe;
        logic acc_ld;
        logic acc_oe;
        logic b_ld;
        logic alu_oe;
        logic alu_sub;
        logic out_ld;
    } ctl_t;

    // bus source slots
    localparam int SRC_PC  = 0;
    localparam int SRC_MEM = 1;
    localparam int SRC_IR  = 2;
    localparam int SRC_ACC = 3;
    localparam int SRC_ALU = 4;
    localparam int NSRC    = 5;

endpackage

// File: rtl/busacc_reg.sv
module busacc_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end
endmodule

// File: rtl/busacc_alu.sv
module busacc_alu #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);
    logic [W-1:0] b_eff;
    logic [W-1:0] cin;

    always_comb begin
        b_eff = sub ? ~b : b;
        cin   = {{(W-1){1'b0}}, sub};
        y     = a + b_eff + cin;
    end
endmodule

// File: rtl/busacc_mem.sv
module busacc_mem #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[addr] <= wdata;
        end
    end

    assign rdata = store[addr];
endmodule

// File: rtl/busacc_ctrl.sv
module busacc_ctrl
    import busacc_pkg::*;
(
    input  logic       clk,
    input  logic       clr,
    input  logic       prog_mode,
    input  logic [3:0] opcode,
    output ctl_t       ctl,
    output logic       halted
);
    state_e state_q;
    state_e state_d;

    // state register
    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            state_q <= ST_ADDR;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (prog_mode && state_q != ST_HALT) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_ADDR:  state_d = ST_INCR;
                ST_INCR:  state_d = ST_FETCH;
                ST_FETCH: state_d = ST_EX1;
                ST_EX1:   state_d = (opcode == OP_HLT) ? ST_HALT : ST_EX2;
                ST_EX2:   state_d = ST_EX3;
                ST_EX3:   state_d = ST_ADDR;
                ST_HALT:  state_d = ST_HALT;
                default:  state_d = ST_ADDR;
            endcase
        end
    end

    // control word per state
    always_comb begin
        ctl = '0;
        if (!prog_mode) begin
            unique case (state_q)
                ST_ADDR: begin
                    ctl.pc_oe  = 1'b1;
                    ctl.mar_ld = 1'b1;
                end
                ST_INCR: begin
                    ctl.pc_inc = 1'b1;
                end
                ST_FETCH: begin
                    ctl.mem_oe = 1'b1;
                    ctl.ir_ld  = 1'b1;
                end
                ST_EX1: begin
                    case (opcode)
                        OP_LDA, OP_ADD, OP_SUB: begin
                            ctl.ir_oe  = 1'b1;
                            ctl.mar_ld = 1'b1;
                        end
                        OP_OUT: begin
                            ctl.acc_oe = 1'b1;
                            ctl.out_ld = 1'b1;
                        end
                        default: ;
                    endcase
                end
                ST_EX2: begin
                    case (opcode)
                        OP_LDA: begin
                            ctl.mem_oe = 1'b1;
                            ctl.acc_ld = 1'b1;
                        end
                        OP_ADD, OP_SUB: begin
                            ctl.mem_oe = 1'b1;
                            ctl.b_ld   = 1'b1;
                        end
                        default: ;
                    endcase
                end
                ST_EX3: begin
                    case (opcode)
                        OP_ADD: begin
                            ctl.alu_oe = 1'b1;
                            ctl.acc_ld = 1'b1;
                        end
                        OP_SUB: begin
                            ctl.alu_oe  = 1'b1;
                            ctl.alu_sub = 1'b1;
                            ctl.acc_ld  = 1'b1;
                        end
                        default: ;
                    endcase
                end
                ST_HALT: ;
                default: ;
            endcase
        end
    end

    assign halted = (state_q == ST_HALT);
endmodule

// File: rtl/busacc_cpu.sv
module busacc_cpu
    import busacc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              prog_mode,
    input  logic              prog_we,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    output logic [DATA_W-1:0] leds,
    output logic              halted
);
    localparam int PAD_W = DATA_W - ADDR_W;

    ctl_t              ctl;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] mar_q;
    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] b_q;
    logic [DATA_W-1:0] out_q;
    logic [DATA_W-1:0] mem_rd;
    logic [DATA_W-1:0] alu_y;
    logic [DATA_W-1:0] bus;
    logic [DATA_W-1:0] src [NSRC];
    logic [NSRC-1:0]   bus_en;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_we;

    // program counter
    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            pc_q <= '0;
        end else if (ctl.pc_inc) begin
            pc_q <= pc_q + 1'b1;
        end
    end

    // bus: gated OR of the enabled source
    assign src[SRC_PC]  = {{PAD_W{1'b0}}, pc_q};
    assign src[SRC_MEM] = mem_rd;
    assign src[SRC_IR]  = {{PAD_W{1'b0}}, ir_q[ADDR_W-1:0]};
    assign src[SRC_ACC] = acc_q;
    assign src[SRC_ALU] = alu_y;

    always_comb begin
        bus_en          = '0;
        bus_en[SRC_PC]  = ctl.pc_oe;
        bus_en[SRC_MEM] = ctl.mem_oe;
        bus_en[SRC_IR]  = ctl.ir_oe;
        bus_en[SRC_ACC] = ctl.acc_oe;
        bus_en[SRC_ALU] = ctl.alu_oe;
    end

    always_comb begin
        bus = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (bus_en[i]) begin
                bus = bus | src[i];
            end
        end
    end

    // memory addressing
    assign mem_addr = prog_mode ? prog_addr : mar_q;
    assign mem_we   = prog_mode & prog_we;

    busacc_mem #(.DW(DATA_W), .AW(ADDR_W)) mem_i (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (prog_data),
        .rdata (mem_rd)
    );

    busacc_reg #(.W(ADDR_W)) mar_i (
        .clk (clk), .clr (clr), .en (ctl.mar_ld),
        .d (bus[ADDR_W-1:0]), .q (mar_q)
    );

    busacc_reg #(.W(DATA_W)) ir_i (
        .clk (clk), .clr (clr), .en (ctl.ir_ld), .d (bus), .q (ir_q)
    );

    busacc_reg #(.W(DATA_W)) acc_i (
        .clk (clk), .clr (clr), .en (ctl.acc_ld), .d (bus), .q (acc_q)
    );

    busacc_reg #(.W(DATA_W)) b_i (
        .clk (clk), .clr (clr), .en (ctl.b_ld), .d (bus), .q (b_q)
    );

    busacc_reg #(.W(DATA_W)) out_i (
        .clk (clk), .clr (clr), .en (ctl.out_ld), .d (bus), .q (out_q)
    );

    busacc_alu #(.W(DATA_W)) alu_i (
        .a   (acc_q),
        .b   (b_q),
        .sub (ctl.alu_sub),
        .y   (alu_y)
    );

    busacc_ctrl ctrl_i (
        .clk       (clk),
        .clr       (clr),
        .prog_mode (prog_mode),
        .opcode    (ir_q[DATA_W-1 -: 4]),
        .ctl       (ctl),
        .halted    (halted)
    );

    assign leds = out_q;
endmodule

// File: rtl/busacc_chk.sv
module busacc_chk
    import busacc_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          clr,
    input logic          prog_mode,
    input logic [NSRC-1:0] bus_en,
    input ctl_t          ctl,
    input logic [DW-1:0] acc,
    input logic [DW-1:0] breg,
    input logic [DW-1:0] leds,
    input logic          halted
);
    assert_one_driver_R9: assert property (@(posedge clk) disable iff (clr)
        $onehot0(bus_en));

    assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (clr)
        halted |=> halted);

    assert_halt_frozen_R7: assert property (@(posedge clk) disable iff (clr)
        halted |=> ($stable(leds) && $stable(acc)));

    assert_prog_idle_R1: assert property (@(posedge clk) disable iff (clr)
        (prog_mode && !halted) |=> ($stable(leds) && $stable(acc)));

    assert_add_result_R4: assert property (@(posedge clk) disable iff (clr)
        (ctl.acc_ld && ctl.alu_oe && !ctl.alu_sub) |=> (acc == ($past(acc) + $past(breg))));

    assert_sub_result_R5: assert property (@(posedge clk) disable iff (clr)
        (ctl.acc_ld && ctl.alu_oe && ctl.alu_sub) |=> (acc == ($past(acc) - $past(breg))));
endmodule

bind busacc_cpu busacc_chk #(.DW(DATA_W)) chk_i (
    .clk       (clk),
    .clr       (clr),
    .prog_mode (prog_mode),
    .bus_en    (bus_en),
    .ctl       (ctl),
    .acc       (acc_q),
    .breg      (b_q),
    .leds      (leds),
    .halted    (halted)
);

// File: tb/busacc_cpu_tb.sv
`timescale 1ns/1ps
module busacc_cpu_tb_top;
    logic       clk = 1'b0;
    logic       clr = 1'b0;
    logic       prog_mode = 1'b0;
    logic       prog_we = 1'b0;
    logic [3:0] prog_addr = '0;
    logic [7:0] prog_data = '0;
    logic [7:0] leds;
    logic       halted;

    int nchk = 0;
    int nerr = 0;
    logic [7:0] img [16];

    always #2 clk = ~clk;

    busacc_cpu dut_i (
        .clk       (clk),
        .clr       (clr),
        .prog_mode (prog_mode),
        .prog_we   (prog_we),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .leds      (leds),
        .halted    (halted)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_image();
        for (int j = 0; j < 16; j++) img[j] = 8'h00;
    endtask

    // clear, then write the image in program mode
    task automatic load_image();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk("R2 clear leds", leds, 0);
        chk("R2 clear halted", halted, 0);
        prog_mode = 1'b1;
        for (int j = 0; j < 16; j++) begin
            prog_addr = 4'(j);
            prog_data = img[j];
            prog_we   = 1'b1;
            @(negedge clk);
        end
        prog_we = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 idle in program mode leds", leds, 0);
        chk("R1 idle in program mode halted", halted, 0);
    endtask

    task automatic run_to_halt(output int cyc, input bit poke,
                               input logic [3:0] paddr, input logic [7:0] pdata);
        prog_mode = 1'b0;
        if (poke) begin
            prog_we   = 1'b1;
            prog_addr = paddr;
            prog_data = pdata;
        end
        cyc = 0;
        while (!halted && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
        prog_we = 1'b0;
    endtask

    task automatic run_expr(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                            input logic [7:0] d, input logic [7:0] e, input int idx, input bit poke);
        logic [7:0] exp;
        int cyc;
        exp = 8'((int'(a) + int'(b) - int'(c) + int'(d) - int'(e)) & 255);
        clear_image();
        img[0]  = 8'h09;
        img[1]  = 8'h1A;
        img[2]  = 8'h2B;
        img[3]  = 8'h1C;
        img[4]  = 8'h2D;
        img[5]  = 8'hE0 | 8'(idx % 16);
        img[6]  = 8'hF0 | 8'((idx * 3) % 16);
        img[7]  = 8'h0E;
        img[8]  = 8'hE0;
        img[9]  = a;
        img[10] = b;
        img[11] = c;
        img[12] = d;
        img[13] = e;
        img[14] = ~exp;
        load_image();
        run_to_halt(cyc, poke, 4'hA, ~b);
        chk("R8 halt cycle count", cyc, 40);
        chk("R4/R5/R9 chain result, R6 low nibble ignored, R11 run writes ignored", leds, exp);
        repeat (20) @(negedge clk);
        chk("R7 frozen after halt, low nibble ignored", leds, exp);
        chk("R7 halted stays high", halted, 1);
    endtask

    initial begin
        #(4 * 150000);
        nerr++;
        $display("FAIL watchdog all requirements actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int cyc;
        // initial clear state
        clr = 1'b1;
        repeat (2) @(negedge clk);
        clr = 1'b0;
        chk("R2 reset leds", leds, 0);
        chk("R2 reset halted", halted, 0);

        // arithmetic sweep
        for (int i = 0; i < 40; i++) begin
            run_expr(8'((i * 37 + 5) % 256), 8'((i * 91 + 17) % 256), 8'((i * 13 + 200) % 256),
                     8'((i * 59 + 3) % 256), 8'((i * 111 + 250) % 256), i, (i % 2) == 1);
        end
        // wrap corners
        run_expr(8'd255, 8'd1, 8'd0, 8'd0, 8'd0, 3, 1'b0);
        run_expr(8'd0, 8'd0, 8'd1, 8'd0, 8'd0, 5, 1'b0);
        run_expr(8'd128, 8'd128, 8'd0, 8'd0, 8'd0, 7, 1'b1);
        run_expr(8'd200, 8'd0, 8'd201, 8'd255, 8'd255, 0, 1'b0);

        // R3 plain load and output
        for (int k = 0; k < 6; k++) begin
            logic [7:0] v;
            v = (k == 0) ? 8'h00 : (k == 1) ? 8'h01 : (k == 2) ? 8'h7F :
                (k == 3) ? 8'h80 : (k == 4) ? 8'hFF : 8'h5A;
            clear_image();
            img[0]  = 8'h0F;
            img[1]  = 8'hE0;
            img[2]  = 8'hF0;
            img[15] = v;
            load_image();
            run_to_halt(cyc, 1'b0, 4'h0, 8'h00);
            chk("R3 load then output", leds, v);
            chk("R8 halt cycle count two instructions", cyc, 16);
        end

        // R10 undefined opcodes are no-ops
        clear_image();
        img[0] = 8'h09;
        img[1] = 8'h3A;
        img[2] = 8'h7B;
        img[3] = 8'hC5;
        img[4] = 8'hE0;
        img[5] = 8'hF0;
        img[9] = 8'h66;
        for (int j = 10; j < 16; j++) img[j] = 8'h11;
        load_image();
        run_to_halt(cyc, 1'b0, 4'h0, 8'h00);
        chk("R10 undefined opcodes leave accumulator", leds, 8'h66);
        chk("R10 cycle count", cyc, 34);

        // R8 program counter wrap
        clear_image();
        img[0] = 8'hE0;
        for (int j = 1; j < 15; j++) img[j] = 8'h1F;
        img[15] = 8'h01;
        load_image();
        prog_mode = 1'b0;
        repeat (50) @(negedge clk);
        chk("R8 first pass output", leds, 8'h00);
        repeat (60) @(negedge clk);
        chk("R8 wrap reaches word 0 again", leds, 8'h1F);
        chk("R8 no halt in loop", halted, 0);

        // R1 program mode mid-run freezes outputs
        prog_mode = 1'b1;
        repeat (30) @(negedge clk);
        chk("R1 program mode holds leds", leds, 8'h1F);
        prog_mode = 1'b0;

        // R2 clear after activity
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk("R2 clear zeroes leds", leds, 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule